// File: doc/BRIEF.md
# Multi-Page-Size Address Translation Buffer

This block translates 64-bit virtual addresses into 48-bit physical addresses through a fully associative array of translation entries. Each entry carries its own page size, from 64 KB up to 4 GB in steps of four. Entries of all sizes share one array, and the page-number compare is masked differently for each entry. A lookup returns, one cycle later, a hit with the composed physical address, a miss, or a fault when the virtual address is malformed.

Software or a walker installs entries through a fill port. The slot for each fill is chosen by a round-robin pointer. A single invalidate-all strobe empties the whole array. The physical address is built from three parts. The entry supplies the space selector and the node number. The virtual address supplies the offset bits below the page boundary, and the entry's frame bits supply the offset bits above it.

Top module: `mps_tlb`

## Requirements
- R1: After reset no entry is valid. All response outputs are 0, and any well-formed lookup reports a miss.
- R2: A lookup presented with `lk_valid` high in cycle N is answered in cycle N+1 with `rsp_valid` high. In a cycle after one without a lookup, `rsp_valid`, `rsp_hit`, `rsp_miss`, `rsp_fault` and `rsp_multi` are all 0.
- R3: A lookup faults when virtual bits 61:48 are not all zero or when the region field in bits 63:62 equals 3. A faulting lookup shows `rsp_fault`=1, `rsp_hit`=0 and `rsp_miss`=0, whatever the array holds.
- R4: Size code c (0..8) gives a page of 2^(16+2c) bytes. An entry hits when it is valid, its region equals bits 63:62, and its stored page number equals virtual bits 47:16 on all bits at positions 2c and above. A well-formed lookup with no such entry reports `rsp_miss`=1.
- R5: On a hit, `rsp_paddr` is formed as follows. Bits 47:46 are the entry's space field and bits 45:36 are its node number. Each offset bit j in 35:0 comes from virtual bit j when j < 16+2c, and from frame bit j-16 otherwise.
- R6: An entry written with a size code of 9 to 15 never hits.
- R7: When several entries hit, the entry with the lowest index supplies the address and `rsp_multi`=1. With exactly one hit, `rsp_multi`=0.
- R8: Each fill writes the slot under a round-robin pointer, which starts at slot 0 and wraps after the last slot. The fill that follows a full sweep therefore replaces the oldest entry.
- R9: `inv_all` clears every valid bit in one cycle and returns the pointer to slot 0. A fill in the same cycle is discarded.
- R10: A lookup in the same cycle as a fill sees the array as it was before that fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_vaddr | input | 64 | Virtual address to translate |
| fill_en | input | 1 | Write one entry at the round-robin slot |
| fill_region | input | 2 | Region tag of the new entry |
| fill_vpn | input | 32 | Virtual bits 47:16 of the new page |
| fill_size | input | 4 | Page size code (0..8 valid) |
| fill_pspace | input | 2 | Physical space selector (PA 47:46) |
| fill_node | input | 10 | Node number (PA 45:36) |
| fill_frame | input | 20 | Frame bits (PA 35:16) |
| inv_all | input | 1 | Invalidate every entry |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | Well-formed address with no entry |
| rsp_fault | output | 1 | Malformed virtual address |
| rsp_multi | output | 1 | More than one entry matched |
| rsp_paddr | output | 48 | Translated physical address on a hit, else 0 |

## Verification
The first pattern sweeps every size code and looks up the first byte, the last byte and the byte just past each page. This separates a correct per-entry mask from a mask that is off by one step. A second probe reuses a matching page number under a different region and shows that the region tag takes part in the compare. Malformed addresses aimed at otherwise live pages separate the fault path from hit and miss. A large page overlapped by a small one probes the priority and multi-hit logic. Two further patterns cover ordering in time. A fill on the same cycle as a lookup shows that the lookup sees the array from before the fill. A sweep of one more fill than there are slots, run after an invalidate, shows that the pointer returns to slot 0 and wraps onto the oldest entry.

// File: rtl/mps_tlb_pkg.sv
`timescale 1ns/1ps
package mps_tlb_pkg;
  localparam int VA_W     = 64;
  localparam int PA_W     = 48;
  localparam int VPN_W    = 32;
  localparam int OFF_W    = 36;
  localparam int MIN_PG   = 16;
  localparam int FRAME_W  = OFF_W - MIN_PG;
  localparam int NODE_W   = 10;
  localparam int SIZE_W   = 4;
  localparam int MAX_CODE = 8;

  typedef struct packed {
    logic [1:0]         region;
    logic [VPN_W-1:0]   vpn;
    logic [SIZE_W-1:0]  size;
    logic [1:0]         pspace;
    logic [NODE_W-1:0]  node;
    logic [FRAME_W-1:0] frame;
  } tlb_entry_t;

  // page-number bits that take part in the compare for a size code
  function automatic logic [VPN_W-1:0] vpn_mask(input logic [SIZE_W-1:0] code);
    logic [VPN_W-1:0] m;
    for (int i = 0; i < VPN_W; i++) m[i] = (i >= 2 * int'(code));
    return m;
  endfunction

  // offset bits that come from the virtual address for a size code
  function automatic logic [OFF_W-1:0] off_mask(input logic [SIZE_W-1:0] code);
    logic [OFF_W-1:0] m;
    for (int j = 0; j < OFF_W; j++) m[j] = (j < MIN_PG + 2 * int'(code));
    return m;
  endfunction
endpackage

// File: rtl/mps_tlb_store.sv
`timescale 1ns/1ps
module mps_tlb_store
  import mps_tlb_pkg::*;
#(
  parameter int ENTRIES = 256,
  localparam int IDX_W  = $clog2(ENTRIES)
)(
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           fill_en,
  input  tlb_entry_t                     fill_data,
  input  logic                           inv_all,
  output tlb_entry_t [ENTRIES-1:0]       ent,
  output logic       [ENTRIES-1:0]       vld
);
  logic [IDX_W-1:0] ptr;
  logic             wr;

  assign wr = fill_en && !inv_all;

  always_ff @(posedge clk) begin
    if (rst)          ptr <= '0;
    else if (inv_all) ptr <= '0;
    else if (fill_en) ptr <= (ptr == IDX_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)          vld <= '0;
    else if (inv_all) vld <= '0;
    else if (fill_en) vld[ptr] <= 1'b1;
  end

  // payload has no reset so it can map onto plain storage
  always_ff @(posedge clk) begin
    if (wr) ent[ptr] <= fill_data;
  end
endmodule

// File: rtl/mps_tlb_match.sv
`timescale 1ns/1ps
module mps_tlb_match
  import mps_tlb_pkg::*;
#(
  parameter int ENTRIES = 256
)(
  input  logic [1:0]                 region,
  input  logic [VPN_W-1:0]           vpn,
  input  tlb_entry_t [ENTRIES-1:0]   ent,
  input  logic [ENTRIES-1:0]         vld,
  output logic [ENTRIES-1:0]         hit_vec
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic size_ok;
    logic tag_ok;
    logic page_ok;
    assign size_ok = (ent[g].size <= SIZE_W'(MAX_CODE));
    assign tag_ok  = (ent[g].region == region);
    assign page_ok = (((ent[g].vpn ^ vpn) & vpn_mask(ent[g].size)) == '0);
    assign hit_vec[g] = vld[g] && size_ok && tag_ok && page_ok;
  end
endmodule

// File: rtl/mps_tlb_prio.sv
`timescale 1ns/1ps
module mps_tlb_prio #(
  parameter int ENTRIES = 256,
  localparam int IDX_W  = $clog2(ENTRIES)
)(
  input  logic [ENTRIES-1:0] hit_vec,
  output logic               any,
  output logic               multi,
  output logic [IDX_W-1:0]   idx
);
  logic [ENTRIES-1:0] rest;

  assign any   = |hit_vec;
  assign rest  = hit_vec & (hit_vec - 1'b1);
  assign multi = |rest;

  always_comb begin
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/mps_tlb.sv
`timescale 1ns/1ps
module mps_tlb
  import mps_tlb_pkg::*;
#(
  parameter int ENTRIES = 256,
  localparam int IDX_W  = $clog2(ENTRIES)
)(
  input  logic               clk,
  input  logic               rst,
  input  logic               lk_valid,
  input  logic [63:0]        lk_vaddr,
  input  logic               fill_en,
  input  logic [1:0]         fill_region,
  input  logic [31:0]        fill_vpn,
  input  logic [3:0]         fill_size,
  input  logic [1:0]         fill_pspace,
  input  logic [9:0]         fill_node,
  input  logic [19:0]        fill_frame,
  input  logic               inv_all,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic               rsp_miss,
  output logic               rsp_fault,
  output logic               rsp_multi,
  output logic [47:0]        rsp_paddr
);
  tlb_entry_t                fill_data;
  tlb_entry_t [ENTRIES-1:0]  ent;
  logic [ENTRIES-1:0]        vld;
  logic [ENTRIES-1:0]        hit_vec;
  logic                      any;
  logic                      multi;
  logic [IDX_W-1:0]          idx;
  tlb_entry_t                sel;
  logic                      bad;
  logic [OFF_W-1:0]          lmask;
  logic [OFF_W-1:0]          offset;

  assign fill_data = '{region: fill_region, vpn: fill_vpn, size: fill_size,
                       pspace: fill_pspace, node: fill_node, frame: fill_frame};

  mps_tlb_store #(.ENTRIES(ENTRIES)) u_store (
    .clk(clk), .rst(rst), .fill_en(fill_en), .fill_data(fill_data),
    .inv_all(inv_all), .ent(ent), .vld(vld)
  );

  mps_tlb_match #(.ENTRIES(ENTRIES)) u_match (
    .region(lk_vaddr[63:62]), .vpn(lk_vaddr[47:16]),
    .ent(ent), .vld(vld), .hit_vec(hit_vec)
  );

  mps_tlb_prio #(.ENTRIES(ENTRIES)) u_prio (
    .hit_vec(hit_vec), .any(any), .multi(multi), .idx(idx)
  );

  assign sel    = ent[idx];
  assign bad    = (lk_vaddr[61:48] != '0) || (lk_vaddr[63:62] == 2'b11);
  assign lmask  = off_mask(sel.size);
  assign offset = (lk_vaddr[OFF_W-1:0] & lmask) | ({sel.frame, {MIN_PG{1'b0}}} & ~lmask);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_multi <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_fault <= lk_valid && bad;
      rsp_hit   <= lk_valid && !bad && any;
      rsp_miss  <= lk_valid && !bad && !any;
      rsp_multi <= lk_valid && !bad && multi;
      rsp_paddr <= (lk_valid && !bad && any) ? {sel.pspace, sel.node, offset} : '0;
    end
  end
endmodule

// File: rtl/mps_tlb_chk.sv
`timescale 1ns/1ps
module mps_tlb_chk (
  input logic        clk,
  input logic        rst,
  input logic        lk_valid,
  input logic [63:0] lk_vaddr,
  input logic        inv_all,
  input logic        rsp_valid,
  input logic        rsp_hit,
  input logic        rsp_miss,
  input logic        rsp_fault,
  input logic        rsp_multi,
  input logic [47:0] rsp_paddr
);
  assert_resp_follows_R2: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rsp_valid && !rsp_hit && !rsp_miss && !rsp_fault && !rsp_multi);

  assert_one_outcome_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault}) == 1);

  assert_mbz_fault_R3: assert property (@(posedge clk) disable iff (rst)
    lk_valid && (lk_vaddr[61:48] != '0) |=> rsp_fault && !rsp_hit);

  assert_low_offset_R5: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_paddr[15:0] == $past(lk_vaddr[15:0]));

  assert_multi_implies_hit_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_multi |-> rsp_hit);

  assert_inv_empties_R9: assert property (@(posedge clk) disable iff (rst)
    inv_all ##1 lk_valid |=> !rsp_hit);
endmodule

bind mps_tlb mps_tlb_chk u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .inv_all(inv_all),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
  .rsp_multi(rsp_multi), .rsp_paddr(rsp_paddr)
);

// File: tb/mps_tlb_tb.sv
`timescale 1ns/1ps
module mps_tlb_tb;
  localparam int ENTRIES = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [63:0] lk_vaddr = '0;
  logic        fill_en = 1'b0;
  logic [1:0]  fill_region = '0;
  logic [31:0] fill_vpn = '0;
  logic [3:0]  fill_size = '0;
  logic [1:0]  fill_pspace = '0;
  logic [9:0]  fill_node = '0;
  logic [19:0] fill_frame = '0;
  logic        inv_all = 1'b0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_multi;
  logic [47:0] rsp_paddr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  mps_tlb #(.ENTRIES(ENTRIES)) u_dut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .fill_en(fill_en), .fill_region(fill_region), .fill_vpn(fill_vpn),
    .fill_size(fill_size), .fill_pspace(fill_pspace), .fill_node(fill_node),
    .fill_frame(fill_frame), .inv_all(inv_all),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_fault(rsp_fault), .rsp_multi(rsp_multi), .rsp_paddr(rsp_paddr)
  );

  always #4 clk = ~clk;

  // reference model
  bit          m_valid [ENTRIES];
  logic [1:0]  m_region[ENTRIES];
  logic [31:0] m_vpn   [ENTRIES];
  logic [3:0]  m_size  [ENTRIES];
  logic [1:0]  m_pspace[ENTRIES];
  logic [9:0]  m_node  [ENTRIES];
  logic [19:0] m_frame [ENTRIES];
  int          m_ptr = 0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model(input logic [63:0] va, output logic f, output logic h,
                       output logic mh, output logic [47:0] pa);
    int first;
    int low;
    logic [35:0] hi;
    first = -1;
    f  = (va[61:48] != 0) || (va[63:62] == 2'b11);
    h  = 0; mh = 0; pa = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (m_valid[i] && m_size[i] <= 8 && m_region[i] == va[63:62]) begin
        low = 2 * int'(m_size[i]);
        if ((va[47:16] >> low) == (m_vpn[i] >> low)) begin
          if (first < 0) first = i;
          else mh = 1;
        end
      end
    end
    if (f) mh = 0;
    if (!f && first >= 0) begin
      h  = 1;
      hi = {m_frame[first], 16'h0};
      pa[47:46] = m_pspace[first];
      pa[45:36] = m_node[first];
      for (int j = 0; j < 36; j++)
        pa[j] = (j < 16 + 2 * int'(m_size[first])) ? va[j] : hi[j];
    end
  endtask

  task automatic lookup(input logic [63:0] va, input string req);
    logic f, h, mh;
    logic [47:0] pa;
    model(va, f, h, mh, pa);
    lk_valid = 1; lk_vaddr = va;
    @(negedge clk);
    lk_valid = 0;
    chk(req, "valid", 64'(rsp_valid), 64'd1);
    chk(req, "fault", 64'(rsp_fault), 64'(f));
    chk(req, "hit",   64'(rsp_hit),   64'(h));
    chk(req, "miss",  64'(rsp_miss),  64'(!f && !h));
    chk(req, "multi", 64'(rsp_multi), 64'(mh));
    chk(req, "paddr", 64'(rsp_paddr), 64'(pa));
  endtask

  task automatic fill(input logic [1:0] rg, input logic [31:0] vpn, input logic [3:0] sz,
                      input logic [1:0] ps, input logic [9:0] nd, input logic [19:0] fr);
    fill_en = 1; fill_region = rg; fill_vpn = vpn; fill_size = sz;
    fill_pspace = ps; fill_node = nd; fill_frame = fr;
    @(negedge clk);
    fill_en = 0;
    m_valid[m_ptr] = 1; m_region[m_ptr] = rg; m_vpn[m_ptr] = vpn; m_size[m_ptr] = sz;
    m_pspace[m_ptr] = ps; m_node[m_ptr] = nd; m_frame[m_ptr] = fr;
    m_ptr = (m_ptr + 1) % ENTRIES;
  endtask

  task automatic invalidate(input bit with_fill);
    inv_all = 1;
    fill_en = with_fill; fill_region = 0; fill_vpn = 32'h0077_0000; fill_size = 0;
    @(negedge clk);
    inv_all = 0; fill_en = 0;
    for (int i = 0; i < ENTRIES; i++) m_valid[i] = 0;
    m_ptr = 0;
  endtask

  task automatic t_reset();
    chk("R1", "rsp_valid", 64'(rsp_valid), 0);
    chk("R1", "rsp_hit", 64'(rsp_hit), 0);
    chk("R1", "rsp_paddr", 64'(rsp_paddr), 0);
    lookup(64'h0000_1234_5678_9abc, "R1");
    @(negedge clk);
    chk("R2", "idle valid", 64'(rsp_valid), 0);
    chk("R2", "idle miss", 64'(rsp_miss), 0);
  endtask

  task automatic t_sizes();
    for (int c = 0; c <= 8; c++) begin
      logic [63:0] base;
      logic [63:0] psz;
      base = 64'(c + 1) << 32;
      psz  = 64'd1 << (16 + 2 * c);
      fill(2'b00, base[47:16], 4'(c), 2'(c), 10'(37 * c + 5), 20'hA5C3B ^ 20'(c * 4099));
      lookup(base, "R4");
      lookup(base + psz - 1, "R5");
      lookup(base + psz, "R4");
      lookup(base | (64'b01 << 62), "R4");
    end
  endtask

  task automatic t_fault();
    lookup(64'h0001_0001_0000_0000, "R3");
    lookup(64'h2000_0002_0000_0000, "R3");
    lookup(64'hC000_0001_0000_0000, "R3");
  endtask

  task automatic t_badsize();
    fill(2'b01, 32'h0050_0000, 4'd9, 2'b01, 10'd3, 20'h12345);
    lookup(64'h4000_5000_0000_0000 >> 0 & 64'h4000_0050_0000_0000 | 64'h4000_0050_0000_0000, "R6");
    fill(2'b01, 32'h0051_0000, 4'd15, 2'b01, 10'd3, 20'h12345);
    lookup(64'h4000_0051_0000_0000, "R6");
  endtask

  task automatic t_multi();
    fill(2'b10, 32'h00A0_0000, 4'd8, 2'b10, 10'd100, 20'hF0000);
    fill(2'b10, 32'h00A0_1230, 4'd0, 2'b01, 10'd200, 20'h0ABCD);
    lookup(64'h8000_00A0_1230_4567, "R7");
    lookup(64'h8000_00A0_9999_4567, "R7");
  endtask

  task automatic t_same_cycle();
    logic f, h, mh;
    logic [47:0] pa;
    lk_valid = 1; lk_vaddr = 64'h0000_00E0_0000_0010;
    fill_en = 1; fill_region = 0; fill_vpn = 32'h00E0_0000; fill_size = 0;
    fill_pspace = 0; fill_node = 10'd9; fill_frame = 20'h00E00;
    @(negedge clk);
    lk_valid = 0; fill_en = 0;
    chk("R10", "miss same cycle", 64'(rsp_miss), 1);
    chk("R10", "hit same cycle", 64'(rsp_hit), 0);
    m_valid[m_ptr] = 1; m_region[m_ptr] = 0; m_vpn[m_ptr] = 32'h00E0_0000; m_size[m_ptr] = 0;
    m_pspace[m_ptr] = 0; m_node[m_ptr] = 10'd9; m_frame[m_ptr] = 20'h00E00;
    m_ptr = (m_ptr + 1) % ENTRIES;
    model(64'h0000_00E0_0000_0010, f, h, mh, pa);
    chk("R10", "model hit after", 64'(h), 1);
    lookup(64'h0000_00E0_0000_0010, "R10");
  endtask

  task automatic t_inv_wrap();
    invalidate(1'b1);
    lookup(64'h0000_0077_0000_0000, "R9");
    lookup(64'h0000_00E0_0000_0010, "R9");
    for (int i = 0; i < ENTRIES; i++)
      fill(2'b00, 32'h0100_0000 + 32'(i), 4'd0, 2'b00, 10'(i), 20'(i + 7));
    lookup(64'h0000_0100_0000_0042, "R8");
    fill(2'b00, 32'h0200_0000, 4'd0, 2'b11, 10'd1, 20'h55555);
    lookup(64'h0000_0100_0000_0042, "R8");
    lookup(64'h0000_0100_0001_0042, "R8");
    lookup(64'h0000_0200_0000_ffff, "R8");
  endtask

  initial begin
    for (int i = 0; i < ENTRIES; i++) m_valid[i] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_sizes();
    t_fault();
    t_badsize();
    t_multi();
    t_same_cycle();
    t_inv_wrap();
    @(negedge clk);
    chk("R2", "final idle", 64'(rsp_valid), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not finish actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule